// File: doc/BRIEF.md
# Bus Hold Request Arbiter

This block lets an external master borrow the external memory bus. A request pin from the outside master is synchronised into the clock domain and then gated by an enable bit. While the enable bit is clear the request pin is ignored and the block never disturbs the bus controller. When a gated request is seen, the arbiter stalls the bus controller so that it starts no new cycle. It waits for the cycle in progress to end, grants the bus with an acknowledge output, and one clock later tells the pads to float the address, data and strobe drivers.

While the bus is lent out, a bus-request output tells the outside master that the local controller has an external cycle waiting. When the outside master drops its request, the acknowledge and the float control fall together. The bus-request output falls with them. The stall is kept for one more clock so the drivers are settled before the controller resumes its pending cycle.

The controller is a five-state machine:
- IDLE: no request.
- DRAIN: a request is waiting for the cycle in progress to finish. IDLE goes to DRAIN on a request while the controller is busy. DRAIN goes back to IDLE if the request is withdrawn.
- GRANT: the acknowledge is up and the drivers still drive. IDLE goes to GRANT on a request at a cycle boundary, and DRAIN goes to GRANT once the controller goes idle.
- HELD: the drivers float. GRANT always goes to HELD.
- RESTORE: the drivers are back and the stall remains for one clock. HELD goes to RESTORE when the request goes away, and RESTORE always goes to IDLE.

Top module: `bus_hold_arbiter`

## Requirements
- R1: After reset, hold_ack, bus_req, pad_float and ctl_stall are all 0.
- R2: hold_req passes through a two-flop synchroniser. With the enable set and the controller idle, a request that is first high at clock edge k raises hold_ack after edge k+2.
- R3: While hold_en is 0 and no grant is active, hold_req has no effect: hold_ack, pad_float, bus_req and ctl_stall stay 0.
- R4: hold_ack never rises while ctl_busy was high at the deciding edge. From the moment a request is seen until the release completes, ctl_stall is 1, so the controller starts no new cycle and ctl_busy is never high together with hold_ack.
- R5: When a synchronised request meets ctl_busy low, hold_ack is 1 after the next clock edge. Grant latency is therefore the remaining length of the cycle in progress plus one clock.
- R6: pad_float rises one clock after hold_ack rises and is never 1 while hold_ack is 0.
- R7: bus_req equals ctl_pending while pad_float is 1, and is 0 otherwise.
- R8: One clock after the synchronised request falls, hold_ack, pad_float and bus_req fall together. ctl_stall stays 1 for one further clock, then falls.
- R9: A request withdrawn before the busy cycle ends returns the block to idle with no grant. ctl_stall falls one clock after the synchronised request falls.
- R10: Clearing hold_en while the bus is held acts as a release, with the same sequence as R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_en | input | 1 | Enable bit for the hold function |
| hold_req | input | 1 | Asynchronous bus request from the outside master, active high |
| ctl_busy | input | 1 | Bus controller has an external cycle in progress |
| ctl_pending | input | 1 | Bus controller has an external cycle waiting to start |
| hold_ack | output | 1 | Bus granted to the outside master, active high |
| bus_req | output | 1 | Local controller wants the bus back while it is held |
| pad_float | output | 1 | Float the address, data and strobe pad drivers |
| ctl_stall | output | 1 | Bus controller must not start a new cycle |

## Verification
The hardest situation to reach is a request that appears while the controller is in the middle of a long cycle and already has more cycles queued. The grant must wait for the boundary, and no new cycle may slip in during the two synchroniser clocks. The bench models a bus controller that retries a new cycle on every free clock whenever it sees ctl_stall low, and it raises the request just after such a cycle starts. A second pattern withdraws the request before the busy cycle ends, which exercises the path from DRAIN back to IDLE.

// File: rtl/hold_arb_pkg.sv
package hold_arb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_DRAIN   = 3'd1,
        ST_GRANT   = 3'd2,
        ST_HELD    = 3'd3,
        ST_RESTORE = 3'd4
    } hold_state_t;

endpackage

// File: rtl/hold_sync.sv
module hold_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q = chain[LAST];
endmodule

// File: rtl/hold_fsm.sv
module hold_fsm
    import hold_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic busy,
    input  logic pending,
    output logic ack,
    output logic flt,
    output logic breq,
    output logic stall
);
    hold_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req) state_d = busy ? ST_DRAIN : ST_GRANT;
            end
            ST_DRAIN: begin
                if (!req)       state_d = ST_IDLE;
                else if (!busy) state_d = ST_GRANT;
            end
            ST_GRANT:   state_d = ST_HELD;
            ST_HELD: begin
                if (!req) state_d = ST_RESTORE;
            end
            ST_RESTORE: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ack   = 1'b0;
        flt   = 1'b0;
        breq  = 1'b0;
        stall = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_DRAIN: stall = 1'b1;
            ST_GRANT: begin
                stall = 1'b1;
                ack   = 1'b1;
            end
            ST_HELD: begin
                stall = 1'b1;
                ack   = 1'b1;
                flt   = 1'b1;
                breq  = pending;
            end
            ST_RESTORE: stall = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_en,
    input  logic hold_req,
    input  logic ctl_busy,
    input  logic ctl_pending,
    output logic hold_ack,
    output logic bus_req,
    output logic pad_float,
    output logic ctl_stall
);
    logic req_sync;
    logic req_eff;

    hold_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (hold_req),
        .q     (req_sync)
    );

    assign req_eff = req_sync & hold_en;

    hold_fsm i_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req_eff),
        .busy    (ctl_busy),
        .pending (ctl_pending),
        .ack     (hold_ack),
        .flt     (pad_float),
        .breq    (bus_req),
        .stall   (ctl_stall)
    );
endmodule

// File: rtl/bus_hold_arbiter_chk.sv
module bus_hold_arbiter_chk (
    input logic clk,
    input logic rst_n,
    input logic hold_en,
    input logic ctl_busy,
    input logic ctl_pending,
    input logic hold_ack,
    input logic bus_req,
    input logic pad_float,
    input logic ctl_stall
);
    assert_float_needs_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pad_float |-> hold_ack);

    assert_float_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pad_float) |-> $past(hold_ack));

    assert_grant_at_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_ack) |-> !$past(ctl_busy));

    assert_stall_while_granted_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack |-> ctl_stall);

    assert_breq_only_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (pad_float && ctl_pending));

    assert_release_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_ack) |-> (!pad_float && !bus_req && ctl_stall));

    assert_disabled_no_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_en && !hold_ack) |=> !hold_ack);
endmodule

bind bus_hold_arbiter bus_hold_arbiter_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold_en     (hold_en),
    .ctl_busy    (ctl_busy),
    .ctl_pending (ctl_pending),
    .hold_ack    (hold_ack),
    .bus_req     (bus_req),
    .pad_float   (pad_float),
    .ctl_stall   (ctl_stall)
);

// File: tb/test_bus_hold_arbiter.sv
`timescale 1ns/1ps
module test_bus_hold_arbiter;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hold_en = 1'b0;
    logic hold_req = 1'b0;
    logic ctl_busy = 1'b0;
    logic ctl_pending = 1'b0;
    logic hold_ack, bus_req, pad_float, ctl_stall;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bus_hold_arbiter i_bus_hold_arbiter (
        .clk(clk), .rst_n(rst_n), .hold_en(hold_en), .hold_req(hold_req),
        .ctl_busy(ctl_busy), .ctl_pending(ctl_pending),
        .hold_ack(hold_ack), .bus_req(bus_req), .pad_float(pad_float),
        .ctl_stall(ctl_stall)
    );

    // bench bus controller: retries a cycle on every free clock unless stalled
    int want = 0;
    int cyc_len = 1;
    int busy_left = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            busy_left = 0;
        end else if (busy_left > 0) begin
            busy_left--;
        end else if (want > 0 && !ctl_stall) begin
            busy_left = cyc_len;
            want--;
        end
        ctl_busy = (busy_left != 0);
    end

    // reference model: phase 0 free, 1 waiting, 2 granted, 3 floated, 4 returning
    bit dly[$] = '{1'b0, 1'b0};
    int ph = 0;
    always @(posedge clk) begin
        bit seen;
        if (!rst_n) begin
            ph = 0;
            dly = '{1'b0, 1'b0};
        end else begin
            seen = dly.pop_front() && hold_en;
            case (ph)
                0: if (seen) ph = ctl_busy ? 1 : 2;
                1: if (!seen) ph = 0; else if (!ctl_busy) ph = 2;
                2: ph = 3;
                3: if (!seen) ph = 4;
                default: ph = 0;
            endcase
            dly.push_back(hold_req);
        end
    end

    task automatic check1(string tag, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
        end
    endtask

    // compare every clock, away from the edge
    always @(posedge clk) begin
        #2;
        if (!done) begin
            check1("R2/R5/R8/R10 hold_ack", hold_ack, (ph == 2 || ph == 3));
            check1("R6 pad_float", pad_float, (ph == 3));
            check1("R7 bus_req", bus_req, (ph == 3) && ctl_pending);
            check1("R1/R3/R4/R9 ctl_stall", ctl_stall, (ph != 0));
            check1("R4 no strobe while granted", hold_ack && ctl_busy, 1'b0);
        end
    end

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int wd;
        wd = 0;
        while (!done && wd < 20000) begin
            @(posedge clk);
            wd++;
        end
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(2);
        // R2 R5 R6 R7 R8: request with idle controller
        hold_en = 1'b1;
        hold_req = 1'b1;
        wait_clk(6);
        ctl_pending = 1'b1;
        wait_clk(3);
        ctl_pending = 1'b0;
        wait_clk(2);
        hold_req = 1'b0;
        wait_clk(6);
        // R3: disabled, request ignored
        hold_en = 1'b0;
        hold_req = 1'b1;
        wait_clk(10);
        hold_req = 1'b0;
        wait_clk(4);
        // R4 R5: request during a stream of long cycles
        hold_en = 1'b1;
        cyc_len = 5;
        want = 6;
        wait_clk(2);
        hold_req = 1'b1;
        wait_clk(30);
        hold_req = 1'b0;
        wait_clk(40);
        // R9: request withdrawn before the boundary
        cyc_len = 8;
        want = 2;
        wait_clk(1);
        hold_req = 1'b1;
        wait_clk(3);
        hold_req = 1'b0;
        wait_clk(25);
        // R10: enable cleared while held
        hold_req = 1'b1;
        ctl_pending = 1'b1;
        wait_clk(8);
        hold_en = 1'b0;
        wait_clk(6);
        hold_req = 1'b0;
        hold_en = 1'b1;
        wait_clk(5);
        // R7 R8: quick re-request with pending cycle
        hold_req = 1'b1;
        wait_clk(6);
        hold_req = 1'b0;
        wait_clk(2);
        hold_req = 1'b1;
        wait_clk(8);
        hold_req = 1'b0;
        ctl_pending = 1'b0;
        wait_clk(8);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule